// File: doc/BRIEF.md
# Supply and clock integrity status register

This block is an 8-bit control and status register for the supply and clock supervisor of a microcontroller. The CPU reaches it through a simple bus: an address-decode hit, a read strobe, a write strobe and write data. The register's value is always presented on the read-data port. The block collects hardware indications into status bits:
- the output of a voltage comparator, which is asynchronous and passes through a synchronizer;
- a pulse that reports a low-voltage reset;
- a pulse that reports a watchdog reset;
- a clock fault that shows the safe oscillator has taken over;
- a level that reports the main oscillator has recovered.

The block drives two interrupt requests and a select line that tells the analog side which voltage to compare. The first request is raised when the voltage status flips in either direction. The second is raised by a clock fault.

Each bit clears by its own rule:
- the two reset-cause flags clear when software writes 0 to them;
- the clock-fault bit clears when the register is read, but only after the oscillator has recovered;
- the voltage interrupt clears on an acknowledge pulse, which marks entry into its service routine.

Two static option inputs enable or disable the voltage features and the clock features. When an option is off, the bits that belong to it read as 0.

Top module: `supclk_status`

## Requirements
- R1: After reset, rdData is 8'h00, and voltIrq, clkIrq and srcSel are all 0.
- R2: A write (selHit and wrStb both 1) loads bit 7 (detection source), bit 6 (voltage interrupt enable) and bit 2 (clock interrupt enable) from wrData, and these bits read back one cycle later. srcSel always equals bit 7.
- R3: Bit 3 always reads 0. Writes to bit 5 and bit 1 have no effect on them.
- R4: Bit 5 shows vcmpIn delayed by two clock edges, through the two-flop synchronizer. Bit 5 reads 0 while optLvEnable is 0.
- R5: While bit 6 is 1 and optLvEnable is 1, every change of bit 5, rising or falling, sets voltIrq in the same cycle as the change. No change of bit 5, or bit 6 at 0, leaves voltIrq unset.
- R6: An irqAck pulse clears voltIrq at the next edge.
- R7: Bit 4 is set by lvRstEvt when optLvEnable is 1. A write with wrData[4]=0 clears it, and a write with wrData[4]=1 leaves it unchanged. Bit 4 reads 0 while optLvEnable is 0.
- R8: Bit 0 is set by wdRstEvt. A write with wrData[0]=0 clears it, and a write with wrData[0]=1 leaves it unchanged.
- R9: Bit 1 is set by clkFault when optClkSecEnable is 1. A read (selHit and rdStb both 1) clears it only if clkRecovered is 1 in that cycle. A read while clkRecovered is 0 leaves it at 1.
- R10: While optClkSecEnable is 0, bit 1 is held at 0, clkFault is ignored and clkIrq is 0, whatever the value of bit 2.
- R11: clkIrq is 1 exactly when bit 1 and bit 2 are both 1 and optClkSecEnable is 1.
- R12: A hardware set has priority over a software clear in the same cycle. This covers bits 4 and 0 against a clearing write, bit 1 against a clearing read, and the voltIrq pending state against irqAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selHit | input | 1 | Address decode hit for this register |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register value |
| vcmpIn | input | 1 | Voltage comparator output (asynchronous); 1 = below threshold |
| lvRstEvt | input | 1 | Low-voltage reset cause pulse |
| wdRstEvt | input | 1 | Watchdog reset cause pulse |
| clkFault | input | 1 | Safe oscillator selected after a main clock disturbance |
| clkRecovered | input | 1 | Main oscillator has recovered |
| irqAck | input | 1 | Entry into the voltage interrupt routine |
| optLvEnable | input | 1 | Option: voltage detector enabled |
| optClkSecEnable | input | 1 | Option: clock security enabled |
| voltIrq | output | 1 | Voltage-change interrupt request |
| clkIrq | output | 1 | Clock-fault interrupt request |
| srcSel | output | 1 | Voltage source select: 0 = main supply, 1 = external pin |

## Verification
Several pairs of events can fall in the same cycle: a reset-cause pulse together with a write that clears its flag, a clock fault together with a recovered read, and a voltage edge together with irqAck. The bench provokes these pairs with directed sequences that put both stimuli in one cycle. It also produces them through dense random pulses. Each pair is judged by the rule that the set wins: the flag or the pending request must still read 1 after that edge. A cycle-accurate bench model built from the requirements checks every output after every cycle.

// File: rtl/supclk_pkg.sv
package supclk_pkg;
  parameter int REG_W = 8;
  parameter int SYNC_STAGES = 2;

  localparam int BIT_SRC  = 7;
  localparam int BIT_VIE  = 6;
  localparam int BIT_VFLG = 5;
  localparam int BIT_LVF  = 4;
  localparam int BIT_RSV  = 3;
  localparam int BIT_CIE  = 2;
  localparam int BIT_CDET = 1;
  localparam int BIT_WDF  = 0;

  localparam logic [REG_W-1:0] CFG_MASK =
    REG_W'((1 << BIT_SRC) | (1 << BIT_VIE) | (1 << BIT_CIE));

  typedef struct packed {
    logic wrHit;
    logic setLv;
    logic setWd;
    logic setDet;
    logic clrDet;
    logic detOff;
    logic setPend;
    logic clrPend;
  } strobe_t;
endpackage

// File: rtl/supclk_sync.sv
module supclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic preOut,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= asyncIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= 1'b0;
      else       chain[i] <= chain[i-1];
    end
  end

  assign preOut  = chain[STAGES-2];
  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/supclk_ctrl.sv
module supclk_ctrl
  import supclk_pkg::*;
(
  input  logic    selHit,
  input  logic    rdStb,
  input  logic    wrStb,
  input  logic    lvRstEvt,
  input  logic    wdRstEvt,
  input  logic    clkFault,
  input  logic    clkRecovered,
  input  logic    irqAck,
  input  logic    optLvEnable,
  input  logic    optClkSecEnable,
  input  logic    vSyncPre,
  input  logic    vSyncNow,
  input  logic    vieBit,
  output strobe_t stb
);
  logic vChange;

  assign vChange = vSyncPre ^ vSyncNow;

  always_comb begin
    stb         = '0;
    stb.wrHit   = selHit & wrStb;
    stb.setLv   = optLvEnable & lvRstEvt;
    stb.setWd   = wdRstEvt;
    stb.detOff  = ~optClkSecEnable;
    stb.setDet  = optClkSecEnable & clkFault;
    stb.clrDet  = selHit & rdStb & clkRecovered;
    stb.setPend = optLvEnable & vieBit & vChange;
    stb.clrPend = irqAck;
  end
endmodule

// File: rtl/supclk_dp.sv
module supclk_dp
  import supclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             vSyncNow,
  input  logic             optLvEnable,
  input  logic             optClkSecEnable,
  output logic [REG_W-1:0] rdData,
  output logic             vieBit,
  output logic             srcSel,
  output logic             voltIrq,
  output logic             clkIrq
);
  logic [REG_W-1:0] cfgReg;
  logic lvFlag, wdFlag, detFlag, pendReg;
  logic [REG_W-1:0] statusView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgReg <= '0;
    else if (stb.wrHit) cfgReg <= wrData & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               lvFlag <= 1'b0;
    else if (stb.setLv)                      lvFlag <= 1'b1;
    else if (stb.wrHit && !wrData[BIT_LVF])  lvFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               wdFlag <= 1'b0;
    else if (stb.setWd)                      wdFlag <= 1'b1;
    else if (stb.wrHit && !wrData[BIT_WDF])  wdFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           detFlag <= 1'b0;
    else if (stb.detOff) detFlag <= 1'b0;
    else if (stb.setDet) detFlag <= 1'b1;
    else if (stb.clrDet) detFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendReg <= 1'b0;
    else if (stb.setPend) pendReg <= 1'b1;
    else if (stb.clrPend) pendReg <= 1'b0;
  end

  always_comb begin
    statusView           = '0;
    statusView[BIT_VFLG] = optLvEnable & vSyncNow;
    statusView[BIT_LVF]  = optLvEnable & lvFlag;
    statusView[BIT_CDET] = optClkSecEnable & detFlag;
    statusView[BIT_WDF]  = wdFlag;
  end

  assign rdData  = cfgReg | statusView;
  assign vieBit  = cfgReg[BIT_VIE];
  assign srcSel  = cfgReg[BIT_SRC];
  assign voltIrq = pendReg;
  assign clkIrq  = optClkSecEnable & detFlag & cfgReg[BIT_CIE];
endmodule

// File: rtl/supclk_status.sv
module supclk_status
  import supclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selHit,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             vcmpIn,
  input  logic             lvRstEvt,
  input  logic             wdRstEvt,
  input  logic             clkFault,
  input  logic             clkRecovered,
  input  logic             irqAck,
  input  logic             optLvEnable,
  input  logic             optClkSecEnable,
  output logic             voltIrq,
  output logic             clkIrq,
  output logic             srcSel
);
  strobe_t stb;
  logic vSyncPre, vSyncNow, vieBit;

  supclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(vcmpIn),
    .preOut(vSyncPre), .syncOut(vSyncNow)
  );

  supclk_ctrl u_ctrl (
    .selHit(selHit), .rdStb(rdStb), .wrStb(wrStb),
    .lvRstEvt(lvRstEvt), .wdRstEvt(wdRstEvt),
    .clkFault(clkFault), .clkRecovered(clkRecovered), .irqAck(irqAck),
    .optLvEnable(optLvEnable), .optClkSecEnable(optClkSecEnable),
    .vSyncPre(vSyncPre), .vSyncNow(vSyncNow), .vieBit(vieBit),
    .stb(stb)
  );

  supclk_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .vSyncNow(vSyncNow), .optLvEnable(optLvEnable),
    .optClkSecEnable(optClkSecEnable),
    .rdData(rdData), .vieBit(vieBit), .srcSel(srcSel),
    .voltIrq(voltIrq), .clkIrq(clkIrq)
  );
endmodule

// File: rtl/supclk_status_chk.sv
module supclk_status_chk
  import supclk_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             selHit,
  input logic             rdStb,
  input logic             wrStb,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             wdRstEvt,
  input logic             clkRecovered,
  input logic             optLvEnable,
  input logic             optClkSecEnable,
  input logic             voltIrq,
  input logic             clkIrq
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BIT_RSV] == 1'b0); // R3

  AST_CLKIRQ_OPT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !optClkSecEnable |-> !clkIrq); // R10

  AST_CLKIRQ_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    clkIrq |-> (rdData[BIT_CDET] && rdData[BIT_CIE])); // R11

  AST_PEND_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(voltIrq) && optLvEnable && $past(optLvEnable))
      |-> (rdData[BIT_VFLG] != $past(rdData[BIT_VFLG]))); // R5

  AST_WD_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (selHit && wrStb && !wrData[BIT_WDF] && !wdRstEvt) |=> !rdData[BIT_WDF]); // R8

  AST_WD_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wdRstEvt |=> rdData[BIT_WDF]); // R12

  AST_DET_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_CDET] && optClkSecEnable && !(selHit && rdStb && clkRecovered))
      |=> (rdData[BIT_CDET] || !optClkSecEnable)); // R9
endmodule

bind supclk_status supclk_status_chk u_chk (.*);

// File: tb/test_supclk_status.sv
module test_supclk_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selHit = 0, rdStb = 0, wrStb = 0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic vcmpIn = 0, lvRstEvt = 0, wdRstEvt = 0, clkFault = 0, clkRecovered = 0, irqAck = 0;
  logic optLvEnable = 1, optClkSecEnable = 1;
  logic voltIrq, clkIrq, srcSel;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  supclk_status i_supclk_status (
    .clk(clk), .rstN(rstN), .selHit(selHit), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .vcmpIn(vcmpIn), .lvRstEvt(lvRstEvt),
    .wdRstEvt(wdRstEvt), .clkFault(clkFault), .clkRecovered(clkRecovered),
    .irqAck(irqAck), .optLvEnable(optLvEnable), .optClkSecEnable(optClkSecEnable),
    .voltIrq(voltIrq), .clkIrq(clkIrq), .srcSel(srcSel)
  );

  // Reference model built from the requirements
  logic mS1, mS2, mPend, mSel, mVie, mCie, mLv, mWd, mDet;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {mS1, mS2, mPend, mSel, mVie, mCie, mLv, mWd, mDet} <= '0;
    end else begin
      mS1 <= vcmpIn;
      mS2 <= mS1;
      if (optLvEnable && mVie && (mS1 != mS2)) mPend <= 1'b1;
      else if (irqAck) mPend <= 1'b0;
      if (selHit && wrStb) begin
        mSel <= wrData[7]; mVie <= wrData[6]; mCie <= wrData[2];
      end
      if (optLvEnable && lvRstEvt) mLv <= 1'b1;
      else if (selHit && wrStb && !wrData[4]) mLv <= 1'b0;
      if (wdRstEvt) mWd <= 1'b1;
      else if (selHit && wrStb && !wrData[0]) mWd <= 1'b0;
      if (!optClkSecEnable) mDet <= 1'b0;
      else if (clkFault) mDet <= 1'b1;
      else if (selHit && rdStb && clkRecovered) mDet <= 1'b0;
    end
  end

  function automatic logic [7:0] expView();
    return {mSel, mVie, optLvEnable & mS2, optLvEnable & mLv, 1'b0,
            mCie, optClkSecEnable & mDet, mWd};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    logic [7:0] e;
    e = expView();
    chk("R2 cfg bits", rdData & 8'hC4, e & 8'hC4);
    chk("R2 srcSel", {7'd0, srcSel}, {7'd0, e[7]});
    chk("R3 reserved bit", {7'd0, rdData[3]}, 8'd0);
    chk("R4 voltage flag", {7'd0, rdData[5]}, {7'd0, e[5]});
    chk("R7 lv flag", {7'd0, rdData[4]}, {7'd0, e[4]});
    chk("R9 clk detect", {7'd0, rdData[1]}, {7'd0, e[1]});
    chk("R8 wd flag", {7'd0, rdData[0]}, {7'd0, e[0]});
    chk("R5 voltIrq", {7'd0, voltIrq}, {7'd0, mPend});
    chk("R11 clkIrq", {7'd0, clkIrq}, {7'd0, optClkSecEnable & mDet & mCie});
  endtask

  // one clock: inputs applied earlier sampled at posedge, checked at negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmpModel();
  endtask

  task automatic idleBus();
    selHit = 0; rdStb = 0; wrStb = 0;
    lvRstEvt = 0; wdRstEvt = 0; clkFault = 0; irqAck = 0;
  endtask

  task automatic doWrite(input logic [7:0] d);
    selHit = 1; wrStb = 1; wrData = d;
    cyc();
    idleBus();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired R1 actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdData reset", rdData, 8'h00);
    chk("R1 irqs reset", {6'd0, voltIrq, clkIrq}, 8'd0);
    chk("R1 srcSel reset", {7'd0, srcSel}, 8'd0);
    rstN = 1;
    cyc();

    // R2/R3: write all ones; bits 5,1 unaffected, bit 3 reads 0
    doWrite(8'hFF);
    chk("R3 write FF readback", rdData, 8'hC4);
    chk("R2 srcSel after write", {7'd0, srcSel}, 8'd1);

    // R5/R6: voltage flag rise with enable set
    vcmpIn = 1; cyc(); cyc();
    chk("R4 flag after two edges", {7'd0, rdData[5]}, 8'd1);
    chk("R5 voltIrq on rise", {7'd0, voltIrq}, 8'd1);
    irqAck = 1; cyc(); irqAck = 0;
    chk("R6 ack clears voltIrq", {7'd0, voltIrq}, 8'd0);
    // R12 pending set vs ack in same cycle: falling edge
    vcmpIn = 0; cyc();
    irqAck = 1; cyc(); irqAck = 0;
    chk("R12 pending set beats ack", {7'd0, voltIrq}, 8'd1);
    irqAck = 1; cyc(); irqAck = 0;

    // R12 reset flags set against clearing write
    lvRstEvt = 1; wdRstEvt = 1; doWrite(8'h00);
    chk("R12 lv set beats clear", {7'd0, rdData[4]}, 8'd1);
    chk("R12 wd set beats clear", {7'd0, rdData[0]}, 8'd1);
    doWrite(8'h11);
    chk("R7 write one keeps lv", {7'd0, rdData[4]}, 8'd1);
    doWrite(8'h04);
    chk("R7 write zero clears lv", {7'd0, rdData[4]}, 8'd0);
    chk("R8 write zero clears wd", {7'd0, rdData[0]}, 8'd0);

    // R9/R11 clock fault and recovery-gated read clear
    clkFault = 1; cyc(); clkFault = 0;
    chk("R11 clkIrq with enable", {7'd0, clkIrq}, 8'd1);
    selHit = 1; rdStb = 1; clkRecovered = 0; cyc(); idleBus();
    chk("R9 read before recovery keeps", {7'd0, rdData[1]}, 8'd1);
    clkFault = 1; selHit = 1; rdStb = 1; clkRecovered = 1; cyc(); idleBus();
    chk("R12 fault beats read clear", {7'd0, rdData[1]}, 8'd1);
    selHit = 1; rdStb = 1; clkRecovered = 1; cyc(); idleBus();
    chk("R9 read after recovery clears", {7'd0, rdData[1]}, 8'd0);

    // R10 clock option off
    optClkSecEnable = 0; clkFault = 1; cyc(); clkFault = 0; cyc();
    chk("R10 detect forced 0", {7'd0, rdData[1]}, 8'd0);
    chk("R10 clkIrq off", {7'd0, clkIrq}, 8'd0);
    optClkSecEnable = 1;

    // R4/R7 voltage option off
    optLvEnable = 0; vcmpIn = 1; lvRstEvt = 1; cyc(); lvRstEvt = 0; cyc(); cyc();
    chk("R4 flag masked", {7'd0, rdData[5]}, 8'd0);
    chk("R7 lv masked", {7'd0, rdData[4]}, 8'd0);
    vcmpIn = 0; cyc(); cyc(); cyc();
    optLvEnable = 1; cyc();

    // Random phases with options fixed per phase
    for (int ph = 0; ph < 4; ph++) begin
      optLvEnable = (ph != 2);
      optClkSecEnable = (ph != 3);
      cyc();
      for (int n = 0; n < 2000; n++) begin
        selHit = ($urandom % 2) == 0;
        rdStb = ($urandom % 10) < 3;
        wrStb = ($urandom % 10) < 3;
        wrData = 8'($urandom);
        if (($urandom % 10) == 0) vcmpIn = ~vcmpIn;
        lvRstEvt = ($urandom % 20) == 0;
        wdRstEvt = ($urandom % 20) == 0;
        clkFault = ($urandom % 20) == 0;
        clkRecovered = ($urandom % 2) == 0;
        irqAck = ($urandom % 10) == 0;
        cyc();
      end
      idleBus();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule